// File: doc/BRIEF.md
# RTC Digital Trim Corrector

This block sits between a 32 kHz tick source and the ripple counter of a real-time clock. On each enabled tick it tells the counter how far to move. The advance is 0, 1 or 2 counts. This allows the clock rate to be calibrated in logic, with no change to the crystal.

The block holds its own interval timer. The timer splits the tick stream into fixed windows, each `WINDOW_TICKS` enabled ticks long (327680 by default, which is ten seconds). At the last tick of each window the block samples a 7-bit trim magnitude N and a direction bit. It then alters the first N enabled ticks of the next window. In insert mode each of those ticks advances the counter twice. In remove mode each of those ticks gives no advance. A window therefore delivers `WINDOW_TICKS + N` or `WINDOW_TICKS - N` counts.

While the RTC enable is low, the block freezes: nothing advances and no correction progresses. The parameter must satisfy `WINDOW_TICKS > 2**7`, so a correction always ends inside its own window.

Top module: `rtc_trim_corrector`

## Requirements
- R1: After reset, `adv_o` and `wrap_o` are 0 while no tick arrives. The window that starts at reset is never corrected: each of its enabled ticks gives exactly one advance.
- R2: `adv_o` encodes the number of counts to add: 0, 1 or 2. The code 3 never appears. A cycle with `tick_i` low gives 0. An enabled tick outside a correction gives 1.
- R3: While `rtc_en_i` is 0, `adv_o` and `wrap_o` are 0. The interval position and any correction still in progress hold their values until the enable returns.
- R4: `wrap_o` is 1 on exactly the `WINDOW_TICKS`-th enabled tick of each window, counted from reset or from the previous wrap, and on no other cycle.
- R5: With direction bit 0 (insert) latched, the first N enabled ticks after a wrap each give `adv_o` = 2.
- R6: With direction bit 1 (remove) latched, the first N enabled ticks after a wrap each give `adv_o` = 0.
- R7: A latched magnitude of 0 leaves every enabled tick of that window at `adv_o` = 1, whatever the direction bit.
- R8: The magnitude and direction are sampled only on a cycle where `wrap_o` is 1. Changes at any other time have no effect on the correction in progress or on the one that follows.
- R9: The sum of `adv_o` over all enabled ticks of a window equals `WINDOW_TICKS` plus N (insert) or minus N (remove), where N and the direction are the values latched at the wrap that opened the window.
- R10: Within one window, the outputs never contain both a double advance and a suppressed enabled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 32 kHz tick, one cycle wide |
| rtc_en_i | input | 1 | RTC enable; 0 freezes the block |
| trim_mag_i | input | 7 | Trim magnitude N, from 0 to 127 |
| trim_remove_i | input | 1 | Direction: 0 inserts counts, 1 removes counts |
| adv_o | output | 2 | Counts to advance this cycle (0, 1 or 2) |
| wrap_o | output | 1 | Pulse on the last tick of each window |

## Verification
Some properties can be checked one cycle at a time, and the checker tests these on every cycle:
- the legal output codes;
- silence while disabled or between ticks;
- the window spacing of `wrap_o`, counted independently;
- the plain first window after reset;
- the rule that one window never mixes insertion with removal.

Other behaviour depends on a value sampled one window earlier, so only the bench's scenarios can show it. This covers:
- the exact corrected tick count per window;
- the sampling of trim only at the wrap, with mid-window changes that must be ignored;
- corrections that resume after the enable is paused;
- the full-scale trim of 127 in both directions.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    localparam int unsigned TRIM_W       = 7;
    localparam int unsigned DEF_WINDOW   = 327680;

    typedef enum logic [1:0] {
        ADV_NONE   = 2'd0,
        ADV_SINGLE = 2'd1,
        ADV_DOUBLE = 2'd2
    } adv_e;

    typedef struct packed {
        logic              remove;
        logic [TRIM_W-1:0] mag;
    } trim_t;

    // Advance for one cycle given whether a tick is counted, whether the
    // correction is active and its direction.
    function automatic adv_e adv_for(input logic step, input logic corr,
                                     input logic remove);
        adv_e r;
        if (!step)       r = ADV_NONE;
        else if (!corr)  r = ADV_SINGLE;
        else if (remove) r = ADV_NONE;
        else             r = ADV_DOUBLE;
        return r;
    endfunction

endpackage

// File: rtl/rtc_interval_timer.sv
module rtc_interval_timer
    import rtc_trim_pkg::*;
#(
    parameter int unsigned WINDOW_TICKS = DEF_WINDOW,
    localparam int unsigned CNT_W = $clog2(WINDOW_TICKS)
) (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output logic wrap_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_TICKS - 1);

    logic [CNT_W-1:0] pos_q;

    assign wrap_o = step_i && (pos_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (step_i) begin
            if (pos_q == LAST) pos_q <= '0;
            else               pos_q <= pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_trim_sequencer.sv
module rtc_trim_sequencer
    import rtc_trim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_i,
    input  logic  wrap_i,
    input  trim_t trim_i,
    output logic  corr_o,
    output logic  remove_o
);

    trim_t             held_q;
    logic [TRIM_W-1:0] left_q;

    assign corr_o   = (left_q != '0);
    assign remove_o = held_q.remove;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            left_q <= '0;
        end else if (wrap_i) begin
            held_q <= trim_i;
            left_q <= trim_i.mag;
        end else if (step_i && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/rtc_adv_select.sv
module rtc_adv_select
    import rtc_trim_pkg::*;
(
    input  logic step_i,
    input  logic corr_i,
    input  logic remove_i,
    output adv_e adv_o
);

    always_comb begin
        adv_o = adv_for(step_i, corr_i, remove_i);
    end

endmodule

// File: rtl/rtc_trim_corrector.sv
module rtc_trim_corrector
    import rtc_trim_pkg::*;
#(
    parameter int unsigned WINDOW_TICKS = DEF_WINDOW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              rtc_en_i,
    input  logic [TRIM_W-1:0] trim_mag_i,
    input  logic              trim_remove_i,
    output logic [1:0]        adv_o,
    output logic              wrap_o
);

    logic  step;
    logic  wrap;
    logic  corr;
    logic  remove;
    trim_t trim_in;
    adv_e  adv;

    assign step    = tick_i && rtc_en_i;
    assign trim_in = '{remove: trim_remove_i, mag: trim_mag_i};

    rtc_interval_timer #(.WINDOW_TICKS(WINDOW_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .wrap_o (wrap)
    );

    rtc_trim_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .wrap_i   (wrap),
        .trim_i   (trim_in),
        .corr_o   (corr),
        .remove_o (remove)
    );

    rtc_adv_select u_sel (
        .step_i   (step),
        .corr_i   (corr),
        .remove_i (remove),
        .adv_o    (adv)
    );

    assign adv_o  = adv;
    assign wrap_o = wrap;

endmodule

// File: rtl/rtc_trim_corrector_chk.sv
module rtc_trim_corrector_chk #(
    parameter int unsigned WINDOW_TICKS = 327680,
    localparam int unsigned CW = $clog2(WINDOW_TICKS) + 1
) (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       rtc_en_i,
    input logic [1:0] adv_o,
    input logic       wrap_o
);

    logic          stp;
    logic [CW-1:0] seen_q;
    logic          first_q;
    logic          dbl_q;
    logic          skip_q;

    assign stp = tick_i && rtc_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= '0;
            first_q <= 1'b1;
            dbl_q   <= 1'b0;
            skip_q  <= 1'b0;
        end else if (stp) begin
            if (wrap_o) begin
                seen_q  <= '0;
                first_q <= 1'b0;
                dbl_q   <= 1'b0;
                skip_q  <= 1'b0;
            end else begin
                seen_q <= seen_q + 1'b1;
                if (adv_o == 2'd2) dbl_q  <= 1'b1;
                if (adv_o == 2'd0) skip_q <= 1'b1;
            end
        end
    end

    // R2: only codes 0..2, and nothing without a tick
    a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
        adv_o != 2'd3);
    a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
        !tick_i |-> (adv_o == 2'd0));
    // R3: disabled means silent
    a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
        !rtc_en_i |-> (adv_o == 2'd0 && !wrap_o));
    // R4: wrap exactly at the last tick of the window
    a_r4_wrap_at_end: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (stp && seen_q == CW'(WINDOW_TICKS - 1)));
    a_r4_end_has_wrap: assert property (@(posedge clk) disable iff (rst)
        (stp && seen_q == CW'(WINDOW_TICKS - 1)) |-> wrap_o);
    // R1: first window after reset is plain
    a_r1_first_plain: assert property (@(posedge clk) disable iff (rst)
        (first_q && stp) |-> (adv_o == 2'd1));
    // R10: one direction per window
    a_r10_no_skip_after_dbl: assert property (@(posedge clk) disable iff (rst)
        (stp && dbl_q) |-> (adv_o != 2'd0));
    a_r10_no_dbl_after_skip: assert property (@(posedge clk) disable iff (rst)
        (stp && skip_q) |-> (adv_o != 2'd2));

endmodule

bind rtc_trim_corrector rtc_trim_corrector_chk #(.WINDOW_TICKS(WINDOW_TICKS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .rtc_en_i (rtc_en_i),
    .adv_o    (adv_o),
    .wrap_o   (wrap_o)
);

// File: tb/rtc_trim_corrector_bench.sv
`timescale 1ns/1ps
module rtc_trim_corrector_bench;

    localparam int W = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       rtc_en_i = 1'b0;
    logic [6:0] trim_mag_i = 7'd0;
    logic       trim_remove_i = 1'b0;
    logic [1:0] adv_o;
    logic       wrap_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;
    string phase = "R1";
    int tick_pct = 80;

    // reference model state
    int m_pos = 0, m_left = 0, m_dev = 0, m_sum = 0;
    bit m_rm = 0;

    always #2.5 clk = ~clk;

    rtc_trim_corrector #(.WINDOW_TICKS(W)) u_rtc_trim_corrector (
        .clk(clk), .rst(rst), .tick_i(tick_i), .rtc_en_i(rtc_en_i),
        .trim_mag_i(trim_mag_i), .trim_remove_i(trim_remove_i),
        .adv_o(adv_o), .wrap_o(wrap_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
        end
    endtask

    // compare, then advance model for the coming edge
    always @(negedge clk) begin
        if (rst) begin
            m_pos = 0; m_left = 0; m_dev = 0; m_sum = 0; m_rm = 0;
        end else begin
            bit st;
            int e_adv;
            bit e_wrap;
            string tg;
            st = tick_i && rtc_en_i;
            e_adv  = !st ? 0 : (m_left > 0 ? (m_rm ? 0 : 2) : 1);
            e_wrap = st && (m_pos == W - 1);
            tg = !rtc_en_i ? "R3" : (!st ? "R2" : (m_left > 0 ? (m_rm ? "R6" : "R5") : "R2"));
            chk(adv_o == e_adv[1:0], tg, adv_o, e_adv);
            chk(wrap_o == e_wrap, "R4", wrap_o, e_wrap);
            if (st) begin
                m_sum += adv_o;
                if (m_pos == W - 1) begin
                    // R9 (R7 when no correction was latched)
                    chk(m_sum == W + m_dev, (m_dev == 0) ? "R7 R9" : "R9", m_sum, W + m_dev);
                    m_dev  = trim_remove_i ? -int'(trim_mag_i) : int'(trim_mag_i);
                    m_rm   = trim_remove_i;
                    m_left = trim_mag_i;
                    m_pos  = 0;
                    m_sum  = 0;
                end else begin
                    m_pos++;
                    if (m_left > 0) m_left--;
                end
            end
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            tick_i = ($urandom_range(99) < tick_pct);
        end
    endtask

    task automatic run_windows(input int k);
        int got;
        got = 0;
        while (got < k) begin
            @(posedge clk); #1;
            tick_i = ($urandom_range(99) < tick_pct);
            if (wrap_o === 1'b1) got++;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(7));
        // R1: reset state with no tick
        repeat (3) @(posedge clk);
        #1 rst = 0; rtc_en_i = 1;
        @(negedge clk);
        chk(adv_o == 2'd0, "R1", adv_o, 0);
        chk(wrap_o == 1'b0, "R1", wrap_o, 0);
        // R1 plain first window, R7 zero trim insert then remove
        trim_mag_i = 7'd0; trim_remove_i = 1'b0;
        run_windows(2);
        phase = "R7";
        trim_remove_i = 1'b1;
        run_windows(2);
        // R5 insertion
        phase = "R5";
        trim_mag_i = 7'd5; trim_remove_i = 1'b0;
        run_windows(2);
        // R8: change mid-window; the ongoing and next correction use sampled value
        phase = "R8";
        run(40);
        trim_mag_i = 7'd20; trim_remove_i = 1'b1;
        run(30);
        trim_mag_i = 7'd9; trim_remove_i = 1'b0;
        run_windows(2);
        // R6 removal with full scale
        phase = "R6";
        trim_mag_i = 7'd127; trim_remove_i = 1'b1;
        run_windows(2);
        // R3: pause mid-correction and resume
        phase = "R3";
        trim_mag_i = 7'd100; trim_remove_i = 1'b0;
        run_windows(1);
        run(20);
        rtc_en_i = 0; run(50);
        rtc_en_i = 1; run(30);
        rtc_en_i = 0; run(15);
        rtc_en_i = 1;
        run_windows(2);
        // R5 full scale insertion with every-cycle ticks
        phase = "R5";
        tick_pct = 100;
        trim_mag_i = 7'd127; trim_remove_i = 1'b0;
        run_windows(2);
        // R1: reset during a correction, first window must be plain again
        phase = "R1";
        tick_pct = 70;
        run(10);
        tick_i = 0; rst = 1;
        @(posedge clk); #1;
        @(posedge clk); #1 rst = 0;
        run_windows(2);
        run(5);
        done = 1;
        summary();
    end

endmodule